// File: doc/BRIEF.md
# LCD Clock and Frame Sequencer

This block produces the phase timing for a segment LCD driver. A power-of-two prescaler and a divider derive a phase period from the input clock. The block then walks through the common-electrode phases of each frame. The number of phases per frame comes from a duty code. Optional idle phases can follow the last common phase of a frame, and a pulse-on window can open at the start of every common phase.

The surrounding driver uses the active common index and the common-active flag to choose which electrode to drive. It uses the phase strobe to update segment levels, and the pulse-on window to time a high-drive burst. It uses the start-of-frame strobe, or the sticky flag, to write new display data between frames. All timing settings are captured only when a frame begins, so a running frame is never cut into pieces with different timing.

Top module: `lcd_frame_seq`

## Requirements
- R1: A phase lasts exactly 2^preSel × D input clock cycles, where D is the effective divider. phaseStb is high in the first cycle of every phase (common or idle) and low in every other cycle.
- R2: The effective divider D equals divSel when divSel is 16 to 31. A divSel below 16 is treated as 16.
- R3: The duty code sets the number of common phases per frame: 0→1, 1→2, 2→3, 3→4, 4→6, 5→8, and codes 6 and 7→8. During common phase k of a frame, comIdx equals k, counting from 0.
- R4: After the last common phase of a frame, deadSel idle phases follow. During an idle phase deadPhase is 1, comActive is 0 and comIdx is 0. With deadSel = 0 the next frame follows at once.
- R5: pulseOn is high during the first pulseSel × 2^preSel cycles of each common phase. It is never high in an idle phase or while the sequencer is off.
- R6: sofStb is high in the first cycle of common phase 0 of every frame, and at no other time.
- R7: sofFlag goes to 1 in the cycle after sofStb and holds until a cycle in which sofClr is 1. A new sofStb in that same cycle wins over the clear.
- R8: running follows enable with one cycle of latency. The first frame starts in the first cycle in which running is 1. Dropping enable returns comIdx, deadPhase, comActive, phaseStb, pulseOn and sofStb to 0 on the next edge, and all counters restart from zero on the next enable.
- R9: preSel, divSel, dutySel, deadSel and pulseSel are sampled only at the clock edge that starts a frame. A change in mid-frame has no effect until the next frame.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Sequencer on/off |
| preSel | input | PRE_W | Prescaler exponent (factor 2^preSel) |
| divSel | input | DIV_W | Divider value, 16 to 31 |
| dutySel | input | 3 | Duty code, common phases per frame |
| deadSel | input | DEAD_W | Idle phases after each frame |
| pulseSel | input | PULSE_W | Pulse-on window length in prescaler periods |
| sofClr | input | 1 | Clear for the start-of-frame flag |
| running | output | 1 | Sequencer is on |
| comIdx | output | 3 | Index of the active common phase |
| comActive | output | 1 | A common phase (not idle) is in progress |
| phaseStb | output | 1 | First cycle of a phase |
| deadPhase | output | 1 | Idle phase in progress |
| pulseOn | output | 1 | Pulse-on window |
| sofStb | output | 1 | First cycle of a frame |
| sofFlag | output | 1 | Sticky start-of-frame flag |

## Verification
The first phase begins in the cycle after the edge that samples enable high. Each later phase begins exactly one phase length after the one before it. sofFlag follows sofStb by one further cycle, and settings take effect only from the edge that starts a frame. The bench drives inputs on the falling edge. It advances a cycle-level reference, built from phase lengths and positions within the frame, on the rising edge, and compares every output on the next falling edge. Each comparison therefore covers exactly the registered state after that edge.

// File: rtl/lcd_seq_pkg.sv
`timescale 1ns/1ps
package lcd_seq_pkg;

  localparam int DUTY_W = 3;
  localparam int COM_W  = 3;

  // strobes from the sequencing control to the timing datapath
  typedef struct packed {
    logic clr;   // hold all counters at zero
    logic load;  // capture timing settings (frame start)
    logic run;   // count input cycles
  } seqStrobe_t;

  function automatic logic [COM_W:0] comCount(input logic [DUTY_W-1:0] code);
    case (code)
      3'd0:    comCount = 4'd1;
      3'd1:    comCount = 4'd2;
      3'd2:    comCount = 4'd3;
      3'd3:    comCount = 4'd4;
      3'd4:    comCount = 4'd6;
      default: comCount = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/lcd_seq_dp.sv
`timescale 1ns/1ps
module lcd_seq_dp
  import lcd_seq_pkg::*;
#(
  parameter int PRE_W   = 4,
  parameter int DIV_W   = 5,
  parameter int DIV_MIN = 16,
  parameter int PULSE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         stb,
  input  logic [PRE_W-1:0]   preSel,
  input  logic [DIV_W-1:0]   divSel,
  input  logic [PULSE_W-1:0] pulseSel,
  output logic               phaseEnd,
  output logic               pulseWin
);

  localparam int PC_W = (1 << PRE_W) - 1;
  localparam int CW   = (DIV_W > PULSE_W) ? DIV_W : PULSE_W;

  logic [PRE_W-1:0]   shPre;
  logic [DIV_W-1:0]   shDiv;
  logic [PULSE_W-1:0] shPulse;
  logic [PC_W-1:0]    preCnt;
  logic [PC_W-1:0]    preMax;
  logic [DIV_W-1:0]   divCnt;
  logic [DIV_W-1:0]   divLoad;
  logic               preLast;
  logic               divLast;

  always_comb begin
    preMax  = PC_W'((64'd1 << shPre) - 64'd1);
    preLast = (preCnt == preMax);
    divLast = (divCnt == shDiv - 1'b1);
    divLoad = (divSel < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : divSel;
  end

  assign phaseEnd = preLast && divLast;
  assign pulseWin = CW'(divCnt) < CW'(shPulse);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shPre   <= '0;
      shDiv   <= DIV_W'(DIV_MIN);
      shPulse <= '0;
    end else if (stb.load) begin
      shPre   <= preSel;
      shDiv   <= divLoad;
      shPulse <= pulseSel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clr) begin
      preCnt <= '0;
      divCnt <= '0;
    end else if (stb.run) begin
      if (preLast) begin
        preCnt <= '0;
        divCnt <= divLast ? '0 : divCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lcd_seq_ctrl.sv
`timescale 1ns/1ps
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
#(
  parameter int DEAD_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DUTY_W-1:0] dutySel,
  input  logic [DEAD_W-1:0] deadSel,
  input  logic              sofClr,
  input  logic              phaseEnd,
  output seqStrobe_t        stb,
  output logic              running,
  output logic              firstCyc,
  output logic              inDead,
  output logic [COM_W-1:0]  comIdx,
  output logic              sofStb,
  output logic              sofFlag
);

  logic [COM_W:0]    shCom;
  logic [DEAD_W-1:0] shDead;
  logic [DEAD_W-1:0] deadCnt;
  logic              lastCom;
  logic              lastDead;
  logic              startCond;
  logic              endFrame;
  logic              stepPhase;

  always_comb begin
    lastCom   = ({1'b0, comIdx} == shCom - 1'b1);
    lastDead  = (deadCnt == shDead - 1'b1);
    startCond = enable && !running;
    stepPhase = running && phaseEnd;
    endFrame  = stepPhase && (inDead ? lastDead : (lastCom && (shDead == '0)));
    stb.clr   = !enable;
    stb.run   = running;
    stb.load  = enable && (startCond || endFrame);
    sofStb    = firstCyc && !inDead && (comIdx == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shCom  <= 4'd1;
      shDead <= '0;
    end else if (stb.load) begin
      shCom  <= comCount(dutySel);
      shDead <= deadSel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      running  <= 1'b0;
      firstCyc <= 1'b0;
      inDead   <= 1'b0;
      comIdx   <= '0;
      deadCnt  <= '0;
    end else begin
      running  <= 1'b1;
      firstCyc <= startCond || stepPhase;
      if (startCond) begin
        inDead  <= 1'b0;
        comIdx  <= '0;
        deadCnt <= '0;
      end else if (stepPhase) begin
        if (inDead) begin
          if (lastDead) inDead <= 1'b0;
          deadCnt <= deadCnt + 1'b1;
        end else if (lastCom) begin
          comIdx  <= '0;
          deadCnt <= '0;
          inDead  <= (shDead != '0);
        end else begin
          comIdx <= comIdx + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) sofFlag <= 1'b0;
    else       sofFlag <= (sofFlag && !sofClr) || sofStb;
  end

endmodule

// File: rtl/lcd_frame_seq.sv
`timescale 1ns/1ps
module lcd_frame_seq
  import lcd_seq_pkg::*;
#(
  parameter int PRE_W   = 4,
  parameter int DIV_W   = 5,
  parameter int DIV_MIN = 16,
  parameter int DEAD_W  = 3,
  parameter int PULSE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [PRE_W-1:0]   preSel,
  input  logic [DIV_W-1:0]   divSel,
  input  logic [2:0]         dutySel,
  input  logic [DEAD_W-1:0]  deadSel,
  input  logic [PULSE_W-1:0] pulseSel,
  input  logic               sofClr,
  output logic               running,
  output logic [2:0]         comIdx,
  output logic               comActive,
  output logic               phaseStb,
  output logic               deadPhase,
  output logic               pulseOn,
  output logic               sofStb,
  output logic               sofFlag
);

  seqStrobe_t stb;
  logic       phaseEnd;
  logic       pulseWin;

  lcd_seq_ctrl #(.DEAD_W(DEAD_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .dutySel  (dutySel),
    .deadSel  (deadSel),
    .sofClr   (sofClr),
    .phaseEnd (phaseEnd),
    .stb      (stb),
    .running  (running),
    .firstCyc (phaseStb),
    .inDead   (deadPhase),
    .comIdx   (comIdx),
    .sofStb   (sofStb),
    .sofFlag  (sofFlag)
  );

  lcd_seq_dp #(
    .PRE_W   (PRE_W),
    .DIV_W   (DIV_W),
    .DIV_MIN (DIV_MIN),
    .PULSE_W (PULSE_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .preSel   (preSel),
    .divSel   (divSel),
    .pulseSel (pulseSel),
    .phaseEnd (phaseEnd),
    .pulseWin (pulseWin)
  );

  assign comActive = running && !deadPhase;
  assign pulseOn   = comActive && pulseWin;

endmodule

// File: rtl/lcd_frame_seq_chk.sv
`timescale 1ns/1ps
module lcd_frame_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sofClr,
  input logic       running,
  input logic [2:0] comIdx,
  input logic       comActive,
  input logic       phaseStb,
  input logic       deadPhase,
  input logic       pulseOn,
  input logic       sofStb,
  input logic       sofFlag
);

  a_r1_hold_in_phase: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running) && !phaseStb) |-> ($stable(comIdx) && $stable(deadPhase)));

  a_r4_dead_no_com: assert property (@(posedge clk) disable iff (!rstN)
    deadPhase |-> (!comActive && comIdx == 3'd0));

  a_r5_no_pulse_idle: assert property (@(posedge clk) disable iff (!rstN)
    (deadPhase || !running) |-> !pulseOn);

  a_r6_sof_on_com0: assert property (@(posedge clk) disable iff (!rstN)
    sofStb |-> (phaseStb && comActive && comIdx == 3'd0));

  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    sofStb |=> sofFlag);

  a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    (sofFlag && sofClr && !sofStb) |=> !sofFlag);

  a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (!phaseStb && !deadPhase && !comActive && comIdx == 3'd0 && !sofStb));

endmodule

bind lcd_frame_seq lcd_frame_seq_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sofClr    (sofClr),
  .running   (running),
  .comIdx    (comIdx),
  .comActive (comActive),
  .phaseStb  (phaseStb),
  .deadPhase (deadPhase),
  .pulseOn   (pulseOn),
  .sofStb    (sofStb),
  .sofFlag   (sofFlag)
);

// File: tb/test_lcd_frame_seq.sv
`timescale 1ns/1ps
module test_lcd_frame_seq;

  logic       clk = 1'b0;
  logic       rstN;
  logic       enable;
  logic [3:0] preSel;
  logic [4:0] divSel;
  logic [2:0] dutySel;
  logic [2:0] deadSel;
  logic [2:0] pulseSel;
  logic       sofClr;
  logic       running;
  logic [2:0] comIdx;
  logic       comActive;
  logic       phaseStb;
  logic       deadPhase;
  logic       pulseOn;
  logic       sofStb;
  logic       sofFlag;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 0;
  string ctx = "R10";

  always #10 clk = ~clk;  // 50 MHz

  lcd_frame_seq i_lcd_frame_seq (
    .clk(clk), .rstN(rstN), .enable(enable), .preSel(preSel), .divSel(divSel),
    .dutySel(dutySel), .deadSel(deadSel), .pulseSel(pulseSel), .sofClr(sofClr),
    .running(running), .comIdx(comIdx), .comActive(comActive), .phaseStb(phaseStb),
    .deadPhase(deadPhase), .pulseOn(pulseOn), .sofStb(sofStb), .sofFlag(sofFlag)
  );

  // reference helpers
  function automatic int phasesOf(input logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 3;
      3'd3: return 4;
      3'd4: return 6;
      default: return 8;
    endcase
  endfunction

  function automatic int effDiv(input logic [4:0] d);  // R2 clamp
    return (d < 5'd16) ? 16 : int'(d);
  endfunction

  // cycle-level reference: position in frame and cycle in phase
  bit mRun, mFlag, sofNow;
  int mPos, mCyc, mLen, mN, mDead, mPulse;

  task automatic snap();
    mLen   = (1 << preSel) * effDiv(divSel);
    mN     = phasesOf(dutySel);
    mDead  = int'(deadSel);
    mPulse = int'(pulseSel) << preSel;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mRun = 0; mFlag = 0; mPos = 0; mCyc = 0;
    end else begin
      sofNow = mRun && mCyc == 0 && mPos == 0;
      mFlag  = (mFlag && !sofClr) || sofNow;
      if (!enable) begin
        mRun = 0; mPos = 0; mCyc = 0;
      end else if (!mRun) begin
        mRun = 1; mPos = 0; mCyc = 0; snap();
      end else begin
        mCyc++;
        if (mCyc == mLen) begin
          mCyc = 0;
          mPos++;
          if (mPos == mN + mDead) begin
            mPos = 0;
            snap();  // R9: settings only at frame start
          end
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", req, ctx, $time, act, exp);
    end
  endtask

  task automatic checkAll();
    bit com;
    com = mRun && mPos < mN;
    chk("R8 running",    int'(running),   int'(mRun));
    chk("R1 phaseStb",   int'(phaseStb),  int'(mRun && mCyc == 0));
    chk("R3 comIdx",     int'(comIdx),    com ? mPos : 0);
    chk("R4 deadPhase",  int'(deadPhase), int'(mRun && mPos >= mN));
    chk("R4 comActive",  int'(comActive), int'(com));
    chk("R5 pulseOn",    int'(pulseOn),   int'(com && mCyc < mPulse));
    chk("R6 sofStb",     int'(sofStb),    int'(mRun && mCyc == 0 && mPos == 0));
    chk("R7 sofFlag",    int'(sofFlag),   int'(mFlag));
  endtask

  task automatic runCycles(input int n, input int clrMode);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      checkAll();
      case (clrMode)
        0: sofClr = 1'b0;
        1: sofClr = 1'b1;
        default: sofClr = ($urandom % 8) == 0;
      endcase
    end
  endtask

  task automatic setCfg(input int p, input int d, input int u, input int dt, input int pw);
    preSel = 4'(p); divSel = 5'(d); dutySel = 3'(u); deadSel = 3'(dt); pulseSel = 3'(pw);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; enable = 1'b0; sofClr = 1'b0;
    setCfg(0, 16, 0, 0, 0);
    // R10: reset state
    ctx = "R10";
    runCycles(4, 0);
    @(negedge clk); rstN = 1'b1;

    // R1 R3 R5 R6: shortest phase, four commons, no idle
    ctx = "R1";
    setCfg(0, 16, 3, 0, 2); enable = 1'b1;
    runCycles(300, 2);

    // R2: divider below 16 runs as 16; R4 idle phases, R5 full window
    enable = 1'b0; runCycles(3, 0);
    ctx = "R2";
    setCfg(1, 3, 5, 2, 7); enable = 1'b1;
    runCycles(1200, 2);

    // R9: settings changed in mid-frame apply only at next frame
    ctx = "R9";
    runCycles(37, 0);
    setCfg(2, 31, 1, 7, 1);
    runCycles(3000, 2);

    // R7: clear held high while frames keep starting (set wins)
    ctx = "R7";
    setCfg(0, 16, 0, 0, 0);
    runCycles(120, 1);
    runCycles(60, 0);

    // R8: disable in mid-phase then restart
    ctx = "R8";
    enable = 1'b0; runCycles(10, 0);
    setCfg(0, 20, 2, 1, 3); enable = 1'b1;
    runCycles(25, 0);
    enable = 1'b0; runCycles(5, 2);
    enable = 1'b1; runCycles(400, 2);

    // constrained random blocks
    ctx = "rand";
    for (int b = 0; b < 220; b++) begin
      if (($urandom % 10) == 0) enable = ~enable;
      else if (($urandom % 4) == 0) enable = 1'b1;
      setCfg($urandom % 3, $urandom % 32, $urandom % 8, $urandom % 8, $urandom % 8);
      runCycles(40 + ($urandom % 300), 2);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog [%s] actual=running expected=done", ctx);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule